// File: doc/BRIEF.md
# Translation Buffer with Dirty-Page Store Trapping

A small fully associative buffer that translates virtual page numbers into physical page numbers. Each slot holds a virtual page number, a physical page number, a valid flag, a write-permission flag and a modified flag. Every lookup returns its result one cycle later, either as a hit carrying the physical page number or as one of three exception codes. A lookup can find no slot holding the page, find a slot that was invalidated, or be a store to a page whose modified flag is clear.

Software keeps the entries up to date through three maintenance ports. A refill installs a translation. A clean page is installed read-only and unmodified, and a dirty page is installed writable and modified. An upgrade turns an existing valid entry into a writable, modified one, typically after a store trap. An invalidate withdraws an entry when its page is evicted. Every store to a clean page traps, so software always sees the first write to a page and can keep an exact modified bit. A refill to a page that is already present reuses that slot. Otherwise the refill takes the lowest-numbered non-valid slot, and if none exists, the slot under a round-robin pointer.

Top module: `xlate_buf`

## Requirements
- R1: After reset no response is signalled (rsp_valid=0), and every page looked up misses until a refill installs it.
- R2: A lookup with no maintenance request in the same cycle produces rsp_valid=1 in the following cycle. With no lookup, rsp_valid=0 in the following cycle. A lookup of a page held by no slot returns rsp_exc=1 (miss) with rsp_hit=0 and rsp_ppn=0.
- R3: A load to a valid entry, or a store to a valid entry whose modified flag is set, returns rsp_hit=1, rsp_exc=0 and the entry's physical page number.
- R4: A store to a valid entry whose modified flag is clear returns rsp_exc=3 (write to unmodified page) with rsp_hit=0 and the entry's physical page number, and it leaves the entry unchanged.
- R5: A refill with fill_dirty=0 installs the page read-only and unmodified. A refill with fill_dirty=1 installs it writable and modified. Either kind sets the valid flag.
- R6: An upgrade of a valid entry makes later stores to it hit. An upgrade of a page that has no valid entry changes nothing.
- R7: After an invalidate, a lookup of that page returns rsp_exc=2 (invalid) while the slot still holds the page. A later refill of the same page makes it hit again.
- R8: A refill of a page that a slot already holds (valid or invalidated) overwrites that slot, replacing its physical page number and status, so no page ever matches two slots.
- R9: A refill of a new page takes the lowest-numbered non-valid slot if one exists. Otherwise it evicts the slot under a round-robin pointer, which starts at slot 0 and advances by one, wrapping, only when it is used.
- R10: Maintenance requests take precedence over a lookup in the same cycle. The lookup is dropped, and rsp_valid=0 follows. Among maintenance requests, refill beats upgrade and upgrade beats invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_store | input | 1 | Lookup is a store (1) or a load (0) |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | VPN_W | Virtual page to install |
| fill_ppn | input | PPN_W | Physical page to install |
| fill_dirty | input | 1 | Page is dirty (1) or clean (0) |
| upg_en | input | 1 | Upgrade-to-writable request |
| upg_vpn | input | VPN_W | Page to upgrade |
| inv_en | input | 1 | Invalidate request |
| inv_vpn | input | VPN_W | Page to invalidate |
| rsp_valid | output | 1 | Response of the previous cycle's lookup |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_exc | output | 2 | 0 none, 1 miss, 2 invalid, 3 store to unmodified page |
| rsp_ppn | output | PPN_W | Physical page of the valid matching entry, else 0 |

## Verification
The hardest state to reach is a full buffer with the round-robin pointer part of the way round, combined with a slot that was invalidated but still holds its page. Only in that state do the precedence between a tag match, a free slot and the pointer and the difference between the invalid and miss codes all matter. The directed sequence fills every slot, evicts twice to move the pointer, invalidates one entry and refills both a fresh page and the invalidated one. A long random phase over a small page range then mixes all five request kinds against the bench model, so overwrites, pointer wraps and same-cycle collisions recur many times.

// File: rtl/xlate_buf.sv
module xlate_buf #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 10,
  parameter int PPN_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_store,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  input  logic             upg_en,
  input  logic [VPN_W-1:0] upg_vpn,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [1:0]       rsp_exc,
  output logic [PPN_W-1:0] rsp_ppn
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [ENTRIES-1:0] live_q, val_q, wr_q, mod_q;
  logic [IW-1:0] ptr_q;

  logic          lk_v, lk_any;
  logic [IW-1:0] lk_idx;
  logic          f_hit, f_free;
  logic [IW-1:0] f_idx, free_idx, victim;
  logic          u_hit, i_hit;
  logic [IW-1:0] u_idx, i_idx;

  always_comb begin
    lk_v = 1'b0; lk_any = 1'b0; lk_idx = '0;
    f_hit = 1'b0; f_idx = '0; f_free = 1'b0; free_idx = '0;
    u_hit = 1'b0; u_idx = '0; i_hit = 1'b0; i_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (val_q[i] && vpn_q[i] == lk_vpn) begin lk_v = 1'b1; lk_idx = IW'(i); end
      if (live_q[i] && vpn_q[i] == lk_vpn) lk_any = 1'b1;
      if (live_q[i] && vpn_q[i] == fill_vpn) begin f_hit = 1'b1; f_idx = IW'(i); end
      if (!val_q[i]) begin f_free = 1'b1; free_idx = IW'(i); end
      if (val_q[i] && vpn_q[i] == upg_vpn) begin u_hit = 1'b1; u_idx = IW'(i); end
      if (live_q[i] && vpn_q[i] == inv_vpn) begin i_hit = 1'b1; i_idx = IW'(i); end
    end
    victim = f_hit ? f_idx : (f_free ? free_idx : ptr_q);
  end

  wire maint   = fill_en | upg_en | inv_en;
  wire lk_go   = lk_req & ~maint;
  wire trap    = lk_store & ~(wr_q[lk_idx] & mod_q[lk_idx]);
  wire use_ptr = fill_en & ~f_hit & ~f_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0; val_q <= '0; wr_q <= '0; mod_q <= '0; ptr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i] <= '0;
        ppn_q[i] <= '0;
      end
    end else if (fill_en) begin
      vpn_q[victim]  <= fill_vpn;
      ppn_q[victim]  <= fill_ppn;
      live_q[victim] <= 1'b1;
      val_q[victim]  <= 1'b1;
      wr_q[victim]   <= fill_dirty;
      mod_q[victim]  <= fill_dirty;
      if (use_ptr) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end else if (upg_en) begin
      if (u_hit) begin
        wr_q[u_idx]  <= 1'b1;
        mod_q[u_idx] <= 1'b1;
      end
    end else if (inv_en) begin
      if (i_hit) val_q[i_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_exc <= 2'd0; rsp_ppn <= '0;
    end else begin
      rsp_valid <= lk_go;
      rsp_hit   <= lk_go & lk_v & ~trap;
      rsp_ppn   <= (lk_go & lk_v) ? ppn_q[lk_idx] : '0;
      if (!lk_go)      rsp_exc <= 2'd0;
      else if (lk_v)   rsp_exc <= trap ? 2'd3 : 2'd0;
      else if (lk_any) rsp_exc <= 2'd2;
      else             rsp_exc <= 2'd1;
    end
  end
endmodule

// File: rtl/xlate_buf_chk.sv
module xlate_buf_chk #(
  parameter int VPN_W = 10,
  parameter int PPN_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_store,
  input logic             fill_en,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PPN_W-1:0] fill_ppn,
  input logic             fill_dirty,
  input logic             upg_en,
  input logic             inv_en,
  input logic [VPN_W-1:0] inv_vpn,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [1:0]       rsp_exc,
  input logic [PPN_W-1:0] rsp_ppn
);
  logic up1;
  always_ff @(posedge clk) up1 <= rst_n;

  wire maint = fill_en | upg_en | inv_en;
  wire go    = lk_req & ~maint;

  a_r10_maint_drops_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && maint) |=> !rsp_valid);

  a_r2_response_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> rsp_valid);

  a_r2_no_request_no_response: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);

  a_r5_dirty_fill_store_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (up1 && $past(fill_en && fill_dirty) && go && lk_store && lk_vpn == $past(fill_vpn))
      |=> rsp_hit);

  a_r5_clean_fill_store_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (up1 && $past(fill_en && !fill_dirty) && go && lk_store && lk_vpn == $past(fill_vpn))
      |=> (rsp_exc == 2'd3 && !rsp_hit));

  a_r3_fill_then_load: assert property (@(posedge clk) disable iff (!rst_n)
    (up1 && $past(fill_en) && go && !lk_store && lk_vpn == $past(fill_vpn))
      |=> (rsp_hit && rsp_ppn == $past(fill_ppn, 2)));

  a_r7_invalidated_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (up1 && $past(inv_en && !fill_en && !upg_en) && go && lk_vpn == $past(inv_vpn))
      |=> !rsp_hit);
endmodule

bind xlate_buf xlate_buf_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_store(lk_store),
  .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dirty(fill_dirty),
  .upg_en(upg_en), .inv_en(inv_en), .inv_vpn(inv_vpn),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_exc(rsp_exc), .rsp_ppn(rsp_ppn)
);

// File: tb/sim_xlate_buf.sv
module sim_xlate_buf;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int VW = 10;
  localparam int PW = 12;

  logic clk = 0, rst_n = 0;
  logic lk_req = 0, lk_store = 0, fill_en = 0, fill_dirty = 0, upg_en = 0, inv_en = 0;
  logic [VW-1:0] lk_vpn = 0, fill_vpn = 0, upg_vpn = 0, inv_vpn = 0;
  logic [PW-1:0] fill_ppn = 0;
  logic rsp_valid, rsp_hit;
  logic [1:0] rsp_exc;
  logic [PW-1:0] rsp_ppn;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_buf #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_store(lk_store),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dirty(fill_dirty),
    .upg_en(upg_en), .upg_vpn(upg_vpn), .inv_en(inv_en), .inv_vpn(inv_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_exc(rsp_exc), .rsp_ppn(rsp_ppn));

  int checks = 0, fails = 0;
  bit done = 0;

  int  m_vpn [N];
  int  m_ppn [N];
  bit  m_live [N];
  bit  m_val [N];
  bit  m_dirty [N];
  int  m_ptr = 0;

  task automatic check(string tag, bit v, bit h, int e, int p);
    checks++;
    if (rsp_valid !== v || rsp_hit !== h || rsp_exc !== 2'(e) || rsp_ppn !== PW'(p)) begin
      fails++;
      $display("FAIL %s: got v=%0b h=%0b exc=%0d ppn=%0h, expected v=%0b h=%0b exc=%0d ppn=%0h",
               tag, rsp_valid, rsp_hit, rsp_exc, rsp_ppn, v, h, e, p);
    end
  endtask

  task automatic cyc(string tag, bit lk, int vpn, bit st,
                     bit f = 0, int fv = 0, int fp = 0, bit fd = 0,
                     bit u = 0, int uv = 0, bit iv = 0, int ivv = 0);
    bit ev = lk && !(f || u || iv);
    bit eh = 0;
    int ee = 0, ep = 0, slot = -1;
    lk_req = lk; lk_vpn = VW'(vpn); lk_store = st;
    fill_en = f; fill_vpn = VW'(fv); fill_ppn = PW'(fp); fill_dirty = fd;
    upg_en = u; upg_vpn = VW'(uv); inv_en = iv; inv_vpn = VW'(ivv);
    if (ev) begin
      bit seen = 0;
      for (int i = 0; i < N; i++) begin
        if (m_val[i] && m_vpn[i] == vpn) slot = i;
        if (m_live[i] && m_vpn[i] == vpn) seen = 1;
      end
      if (slot >= 0) begin
        ep = m_ppn[slot];
        if (st && !m_dirty[slot]) ee = 3; else eh = 1;
      end else ee = seen ? 2 : 1;
    end
    if (f) begin
      slot = -1;
      foreach (m_vpn[i]) if (slot < 0 && m_live[i] && m_vpn[i] == fv) slot = i;
      foreach (m_vpn[i]) if (slot < 0 && !m_val[i]) slot = i;
      if (slot < 0) begin slot = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_vpn[slot] = fv; m_ppn[slot] = fp; m_live[slot] = 1; m_val[slot] = 1; m_dirty[slot] = fd;
    end else if (u) begin
      foreach (m_vpn[i]) if (m_val[i] && m_vpn[i] == uv) m_dirty[i] = 1;
    end else if (iv) begin
      foreach (m_vpn[i]) if (m_live[i] && m_vpn[i] == ivv) m_val[i] = 0;
    end
    @(posedge clk); @(negedge clk);
    check(tag, ev, eh, ee, ep);
  endtask

  task automatic look(string tag, int vpn, bit st);
    cyc(tag, 1, vpn, st);
  endtask
  task automatic fill(string tag, int v, int p, bit d);
    cyc(tag, 0, 0, 0, 1, v, p, d);
  endtask

  initial begin
    for (int c = 0; c < 50000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    foreach (m_vpn[i]) begin m_vpn[i] = 0; m_ppn[i] = 0; m_live[i] = 0; m_val[i] = 0; m_dirty[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", 0, 0, 0, 0);
    rst_n = 1;
    look("R1", 0, 0);
    look("R2", 5, 0);
    fill("R5", 5, 'h11, 0);
    look("R3", 5, 0);
    look("R4", 5, 1);
    look("R4", 5, 1);
    cyc("R6", 0, 0, 0, 0, 0, 0, 0, 1, 5);
    look("R6", 5, 1);
    cyc("R6", 0, 0, 0, 0, 0, 0, 0, 1, 9);
    look("R6", 9, 1);
    fill("R5", 6, 'h22, 1);
    look("R5", 6, 1);
    fill("R8", 5, 'h33, 0);
    look("R8", 5, 0);
    look("R8", 5, 1);
    fill("R9", 7, 'h44, 0);
    fill("R9", 8, 'h55, 1);
    look("R8", 6, 0);
    fill("R9", 10, 'h66, 0);
    look("R9", 5, 0);
    fill("R9", 11, 'h77, 1);
    look("R9", 6, 0);
    look("R9", 7, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 7);
    look("R7", 7, 0);
    fill("R9", 12, 'h88, 0);
    look("R9", 7, 0);
    look("R9", 8, 1);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8);
    look("R7", 8, 1);
    fill("R7", 8, 'h99, 1);
    look("R7", 8, 1);
    cyc("R10", 1, 8, 0, 1, 13, 'haa, 0);
    cyc("R10", 1, 8, 0, 0, 0, 0, 0, 1, 12, 1, 12);
    look("R10", 12, 1);
    cyc("R10", 1, 13, 0, 0, 0, 0, 0, 0, 0, 1, 13);
    look("R7", 13, 0);
    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 9);
      int v  = $urandom_range(0, 7);
      case (op)
        0, 1:    cyc("R8", $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1),
                     1, v, $urandom_range(0, 4095), $urandom_range(0, 1));
        2:       cyc("R6", $urandom_range(0, 1), $urandom_range(0, 7), 1, 0, 0, 0, 0, 1, v);
        3:       cyc("R7", $urandom_range(0, 1), $urandom_range(0, 7), 0, 0, 0, 0, 0, 0, 0, 1, v);
        4:       cyc("R2", 0, 0, 0);
        default: look("R3", v, $urandom_range(0, 1));
      endcase
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule